// File: doc/BRIEF.md
# Glitch-free two-clock switch

This block picks one of two source clocks, which may run at unrelated frequencies and phases, and drives a single output clock from it. Changing the select input never puts a runt pulse or an extra edge on the output. Each source has its own enable. The enable is produced by a two-stage synchronizer clocked by that source. The first stage samples on the rising edge and the second stage updates on the falling edge.

The two sides are cross-coupled. A side may accept a request only when the opposite side is fully idle, meaning nothing is in its synchronizer and its enable is off. The side being released therefore shuts down before the newly chosen side starts. The price of this handshake is a dead interval during every switch: the output stays low for a few source cycles.

A test enable bypasses all of this and drives the test clock straight to the output. The block sits at the root of a clock tree, ahead of the distribution network.

Top module: `gcs_clock_switch`

## Requirements
- R1: Once a switch has completed, `clk_out` follows `clk_a` while `sel` is 0 and follows `clk_b` while `sel` is 1.
- R2: Every high phase and every low phase on `clk_out` lasts at least as long as the shorter half-period of the two sources. This holds no matter when `sel` changes, including changes close to either clock's edges and select pulses withdrawn before a switch completes.
- R3: The two source enables are never on together. A side's synchronizer accepts a request only while the opposite side holds no request in its synchronizer and has its enable off (break-before-make).
- R4: Each source enable changes only at a falling edge of its own clock, so it changes only while that clock is low.
- R5: A switch costs a dead interval during which `clk_out` is low. The new clock is on the output no later than 2 rising edges of the old clock plus 3 rising edges of the new clock after `sel` changes.
- R6: While `rst_n` is low, both synchronizers are cleared and `clk_out` is low. After release with `sel` at 0, the first rising edge of `clk_a` does not reach the output. The output starts with the next rising edge of `clk_a`.
- R7: While `test_en` is 1, `clk_out` equals `test_clk`, whatever the values of `sel` and the enables.
- R8: A change of `sel` has no effect on `clk_out` before the next rising edge of the currently active clock. An enable equals its request as sampled at the previous rising edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Source clock chosen when `sel` is 0 |
| clk_b | input | 1 | Source clock chosen when `sel` is 1 |
| rst_n | input | 1 | Asynchronous active-low reset of both synchronizers |
| sel | input | 1 | Level select, asynchronous to both clocks |
| test_en | input | 1 | Test bypass: routes `test_clk` straight to the output |
| test_clk | input | 1 | Clock used while `test_en` is 1 |
| clk_out | output | 1 | Switched clock |

## Verification
The hardest case is a select that flips and flips back inside one half-period. If the feedback watched only the opposite enable, and not its pending request, both sides would open together. The output would then show an OR of the two clocks, with short phases that the phase-width monitor measures. Selects placed a fraction of a nanosecond after an edge of either clock target enables that move in the wrong phase; such a design would clip a high phase. Reset release is checked for a clipped first pulse. Test mode is checked to keep passing the test clock while `sel` moves underneath it. A design that never finishes a switch, or that lets the new clock through early, fails the per-phase comparison against the selected source.

// File: rtl/gcs_pkg.sv
package gcs_pkg;

    // Number of selectable sources; the cross-coupled handshake is built for a pair.
    localparam int unsigned GCS_NUM_SRC = 2;

    // Select encoding: 0 picks clk_a, 1 picks clk_b.
    typedef enum logic {
        GCS_SRC_A = 1'b0,
        GCS_SRC_B = 1'b1
    } gcs_src_e;

endpackage

// File: rtl/gcs_sync_side.sv
// One side of the switch: request synchronizer on rising edges,
// enable register on the falling edge of the same clock.
module gcs_sync_side #(
    parameter int unsigned FIRST_STAGES = 1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sel_match_i,
    input  logic other_busy_i,
    output logic en_o,
    output logic busy_o
);

    localparam int unsigned LAST = FIRST_STAGES - 1;

    typedef struct packed {
        logic [FIRST_STAGES-1:0] chain;
        logic                    en;
    } side_t;

    side_t                   s_d;
    logic [FIRST_STAGES-1:0] chain_q;
    logic                    en_q;
    logic                    req_w;

    always_comb begin
        req_w        = sel_match_i & ~other_busy_i;
        s_d.chain[0] = req_w;
        for (int k = 1; k < int'(FIRST_STAGES); k++) begin
            s_d.chain[k] = chain_q[k-1];
        end
        s_d.en = chain_q[LAST];
    end

    // Rising-edge stages
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= s_d.chain;
        end
    end

    // Final stage: updates while the clock is low (R4)
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q <= 1'b0;
        end else begin
            en_q <= s_d.en;
        end
    end

    assign en_o   = en_q;
    assign busy_o = (|chain_q) | en_q;

    // R3: when this enable has opened, the opposite side is fully idle
    p_off_before_on_r3: assert property (@(negedge clk_i) disable iff (!rst_ni)
        $rose(en_q) |-> !other_busy_i);

    // R4: the enable only moves while its own clock is low
    always @(en_q) begin
        if (rst_ni) begin
            p_en_low_phase_r4: assert (clk_i == 1'b0);
        end
    end

    // R8: no request at the last rising edge means no enable now
    if (FIRST_STAGES == 1) begin : g_chk_single
        p_first_stage_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !$past(req_w) |-> !en_q);
    end

endmodule

// File: rtl/gcs_clk_merge.sv
// Gates each source with its enable, ORs the results, applies the test bypass.
module gcs_clk_merge #(
    parameter int unsigned NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] src_clk_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  logic               test_en_i,
    input  logic               test_clk_i,
    output logic               clk_o
);

    logic [NUM_SRC-1:0] gated_w;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
        assign gated_w[g] = src_clk_i[g] & en_i[g];
    end

    always_comb begin
        clk_o = test_en_i ? test_clk_i : (|gated_w);
    end

endmodule

// File: rtl/gcs_clock_switch.sv
module gcs_clock_switch
    import gcs_pkg::*;
#(
    parameter int unsigned FIRST_STAGES = 1
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst_n,
    input  logic sel,
    input  logic test_en,
    input  logic test_clk,
    output logic clk_out
);

    logic [GCS_NUM_SRC-1:0] src_w;
    logic [GCS_NUM_SRC-1:0] match_w;
    logic [GCS_NUM_SRC-1:0] en_w;
    logic [GCS_NUM_SRC-1:0] busy_w;

    always_comb begin
        src_w   = {clk_b, clk_a};
        match_w = {sel == GCS_SRC_B, sel == GCS_SRC_A};
    end

    // Cross-coupled pair: each side waits on the other's busy flag
    for (genvar g = 0; g < GCS_NUM_SRC; g++) begin : g_side
        gcs_sync_side #(
            .FIRST_STAGES (FIRST_STAGES)
        ) u_side (
            .clk_i        (src_w[g]),
            .rst_ni       (rst_n),
            .sel_match_i  (match_w[g]),
            .other_busy_i (busy_w[GCS_NUM_SRC-1-g]),
            .en_o         (en_w[g]),
            .busy_o       (busy_w[g])
        );
    end

    gcs_clk_merge #(
        .NUM_SRC (GCS_NUM_SRC)
    ) u_merge (
        .src_clk_i  (src_w),
        .en_i       (en_w),
        .test_en_i  (test_en),
        .test_clk_i (test_clk),
        .clk_o      (clk_out)
    );

    // R3: the two enables, driven from separate domains, never overlap
    always_comb begin
        if (rst_n) begin
            p_mutex_r3: assert (!(en_w[0] && en_w[1]));
        end
    end

endmodule

// File: tb/gcs_clock_switch_tb.sv
`timescale 1ns/10ps
module gcs_clock_switch_tb;

    localparam realtime CLK_PERIOD = 10.0;            // clk_a
    localparam realtime A_HALF     = CLK_PERIOD / 2.0;
    localparam realtime B_HALF     = 8.5;             // clk_b, unrelated
    localparam realtime B_OFFSET   = 1.3;
    localparam realtime T_HALF     = 3.0;             // test clock
    localparam realtime T_OFFSET   = 0.7;
    localparam realtime MIN_PHASE  = A_HALF - 0.01;
    localparam realtime WATCHDOG   = 1000000.0;

    logic clk_a = 1'b0, clk_b = 1'b0, test_clk = 1'b0;
    logic rst_n = 1'b0, sel = 1'b0, test_en = 1'b0;
    logic clk_out;

    int errors = 0;
    int checks = 0;
    bit mon_on = 1'b0;
    bit have_last = 1'b0;
    bit done = 1'b0;
    realtime last_t = 0.0;

    gcs_clock_switch u_dut (
        .clk_a    (clk_a),
        .clk_b    (clk_b),
        .rst_n    (rst_n),
        .sel      (sel),
        .test_en  (test_en),
        .test_clk (test_clk),
        .clk_out  (clk_out)
    );

    initial forever #(A_HALF) clk_a = ~clk_a;
    initial begin #(B_OFFSET); forever #(B_HALF) clk_b = ~clk_b; end
    initial begin #(T_OFFSET); forever #(T_HALF) test_clk = ~test_clk; end

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: clk_out=%b expected %b", tag, $realtime, act, exp);
        end
    endtask

    // Phase-width monitor (R2, R4): no runt high or low phase
    always @(clk_out) begin
        realtime now;
        now = $realtime;
        if (mon_on && have_last) begin
            checks++;
            if (now - last_t < MIN_PHASE) begin
                errors++;
                $display("FAIL R2 phase width at %0t: actual=%0.2f expected>=%0.2f",
                         now, now - last_t, MIN_PHASE);
            end
        end
        last_t    = now;
        have_last = mon_on;
    end

    // Reference: output equals the selected source, sampled mid-phase
    task automatic follow_check(input logic which, input int cycles, input string tag);
        for (int i = 0; i < cycles; i++) begin
            if (which == 1'b0) begin
                @(posedge clk_a); #(A_HALF / 2.0); check_bit(tag, clk_out, 1'b1);
                @(negedge clk_a); #(A_HALF / 2.0); check_bit(tag, clk_out, 1'b0);
            end else begin
                @(posedge clk_b); #(B_HALF / 2.0); check_bit(tag, clk_out, 1'b1);
                @(negedge clk_b); #(B_HALF / 2.0); check_bit(tag, clk_out, 1'b0);
            end
        end
    endtask

    // R5 bound: 2 old + 3 new rising edges; the wait covers more than that
    task automatic wait_settle(input logic old_s, input logic new_s);
        if (old_s == 1'b0) repeat (3) @(posedge clk_a);
        else               repeat (3) @(posedge clk_b);
        if (new_s == 1'b0) repeat (4) @(posedge clk_a);
        else               repeat (4) @(posedge clk_b);
    endtask

    task automatic do_switch(input bit check_old);
        logic old_s;
        old_s = sel;
        sel   = ~sel;
        if (check_old) begin
            #0.02;
            // R8: the old clock is still on the output right after the change
            check_bit("R8", clk_out, old_s ? clk_b : clk_a);
        end
        wait_settle(old_s, sel);
        follow_check(sel, 4, "R1/R5");
    endtask

    initial begin
        #(WATCHDOG);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R5 watchdog at %0t: run not finished, expected completion", $realtime);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R6: output held low through reset, whatever sel does
        #7.3;  check_bit("R6", clk_out, 1'b0);
        sel = 1'b1;
        #11.1; check_bit("R6", clk_out, 1'b0);
        #13.2; check_bit("R6", clk_out, 1'b0);
        sel = 1'b0;
        #9.47;                          // release at 41.07
        rst_n  = 1'b1;
        mon_on = 1'b1;
        #0.02; check_bit("R6", clk_out, 1'b0);
        @(posedge clk_a); #(A_HALF / 2.0);
        check_bit("R6", clk_out, 1'b0); // first edge absorbed by the handshake
        follow_check(1'b0, 4, "R6/R1");

        // Directed switches both ways
        @(negedge clk_a); #0.07; do_switch(1'b1);
        @(negedge clk_a); #0.07; do_switch(1'b1);

        // Select changes just after edges of either clock and at random times
        for (int i = 0; i < 30; i++) begin
            case ($urandom_range(0, 2))
                0: begin @(negedge clk_a); #($urandom_range(0, 150) * 0.1 + 0.07); end
                1: begin @(posedge clk_a); #0.07; end
                default: begin @(negedge clk_b); #0.07; end
            endcase
            do_switch(1'b1);
        end

        // Select pulses withdrawn before the handshake finishes (R2, R3)
        for (int i = 0; i < 12; i++) begin
            logic start_s;
            if (i % 2 == 0) @(posedge clk_b); else @(posedge clk_a);
            #0.07;
            start_s = sel;
            sel = ~sel;
            #($urandom_range(1, 40) * 0.1);
            sel = ~sel;
            if (i % 3 == 0) begin
                #($urandom_range(1, 60) * 0.1);
                sel = ~sel;
            end
            repeat (4) @(posedge clk_a);
            repeat (4) @(posedge clk_b);
            wait_settle(start_s, sel);
            follow_check(sel, 3, "R3/R1");
        end

        // R7: test bypass ignores sel
        @(negedge clk_a); #0.07;
        mon_on  = 1'b0;
        test_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(posedge test_clk); #(T_HALF / 2.0); check_bit("R7", clk_out, 1'b1);
            if (i == 2) sel = ~sel;
            @(negedge test_clk); #(T_HALF / 2.0); check_bit("R7", clk_out, 1'b0);
        end
        test_en = 1'b0;
        wait_settle(~sel, sel);
        mon_on = 1'b1;
        follow_check(sel, 4, "R7/R1");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule